// File: doc/BRIEF.md
# Serial-Port Interrupt Status and Masking

This block collects the interrupt sources of a serial port controller into one 16-bit status word that software can only read. A 16-bit mask register, which software can write and read back, gates the status word. The single interrupt output is high whenever any status bit and its mask bit are both set.

The two modem-control inputs are carrier detect and clear-to-send. Each is synchronised into the clock domain and watched for rising edges, and each line has its own enable. An enabled rising edge sets a sticky input-port-change flag, which stays set until software pulses a dedicated clear strobe.

An overrun event pulse from the receive path latches an overrun flag. Only the reset-error command strobe clears that flag. Writing the mask or clearing the port-change flag leaves it alone. Four level-type sources come straight from the transmit and receive path and are not latched: transmitter empty, receiver ready, FIFO full and transmitter ready.

The clear-to-send input may already be high, or may rise, as the port comes up. The port-change flag can therefore be set by the time software wants that source. Software should pulse the clear strobe before it unmasks the source.

Top module: `sport_irq_top`

## Requirements
- R1: While reset is low at a clock edge, the status word, the mask register and the interrupt output all go to 0.
- R2: The interrupt output is 1 exactly when some status bit and its mask bit are both 1. A set status bit with a clear mask bit has no effect on the output.
- R3: With the carrier-detect enable at 1, a low-to-high change on the carrier-detect input sets the port-change flag (status bit 15; bit 0 when counting from the msb). The flag first reads 1 after the third rising clock edge that samples the new input level.
- R4: With the clear-to-send enable at 1, a low-to-high change on the clear-to-send input sets the same port-change flag, with the same three-edge latency.
- R5: With its enable at 0, a modem input has no effect on the port-change flag.
- R6: The port-change flag stays set until the clear strobe is pulsed. If an enabled edge and the clear strobe arrive in the same cycle, the flag stays set.
- R7: An overrun pulse sets the overrun bit (status bit 12; bit 3 from the msb) on the next edge. Only the reset-error command clears it. If a pulse and the command coincide, the bit stays set. Mask writes and the port-change clear leave the bit unchanged.
- R8: The level bits follow their inputs combinationally: transmitter empty at bit 11, receiver ready at bit 9, FIFO full at bit 8 and transmitter ready at bit 7.
- R9: All other status bits, including the reserved bits 14 and 13 (bits 1 and 2 from the msb), always read 0.
- R10: A mask write takes effect at the next clock edge. The mask reads back on the read port when the read select is 1; the status word appears there when the select is 0.
- R11: A falling edge, or a modem input that stays high, does not set the port-change flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| mask_we | input | 1 | Mask register write strobe |
| mask_wdata | input | 16 | Mask write data |
| rd_sel | input | 1 | Read select: 0 selects the status word, 1 selects the mask |
| rd_data | output | 16 | Read data |
| pchg_clr | input | 1 | Clears the port-change flag |
| err_rst_cmd | input | 1 | Reset-error command; clears the overrun bit |
| cd_in | input | 1 | Carrier-detect modem input (asynchronous) |
| cts_in | input | 1 | Clear-to-send modem input (asynchronous) |
| cd_edge_en | input | 1 | Enables carrier-detect edges to set the port-change flag |
| cts_edge_en | input | 1 | Enables clear-to-send edges to set the port-change flag |
| ovr_evt | input | 1 | Overrun event pulse from the receive path |
| tx_empty | input | 1 | Transmitter empty level |
| rx_ready | input | 1 | Receiver ready level |
| fifo_full | input | 1 | FIFO full level |
| tx_ready | input | 1 | Transmitter ready level |
| irq | output | 1 | Masked interrupt output |

## Verification
The bench builds the block with `SYNC_STAGES` set to 2, the default. With that value the path from a modem input to the flag is exactly three edges, so the bench can sample one cycle early and show the flag still clear, then sample on the expected edge. The same depth lets the bench place the clear strobe in the one cycle where the edge detector fires, which exercises the set-wins rule. The status width is fixed at 16, so every reserved position can be observed through the read port.

// File: rtl/sport_irq_pkg.sv
// Package: shared widths and status-bit positions for the serial-port
// interrupt block. Positions are lsb-indexed; software counts from the msb.
package sport_irq_pkg;
    localparam int WORD_W   = 16;
    localparam int N_MODEM  = 2;        // index 0 = carrier detect, 1 = clear-to-send
    localparam int BIT_PCHG = WORD_W - 1;   // msb-numbered bit 0
    localparam int BIT_OVR  = WORD_W - 4;   // msb-numbered bit 3
    localparam int BIT_TXE  = WORD_W - 5;
    localparam int BIT_RXR  = WORD_W - 7;
    localparam int BIT_FFUL = WORD_W - 8;
    localparam int BIT_TXR  = WORD_W - 9;
    localparam logic [WORD_W-1:0] USED_MASK =
        (WORD_W'(1) << BIT_PCHG) | (WORD_W'(1) << BIT_OVR) |
        (WORD_W'(1) << BIT_TXE)  | (WORD_W'(1) << BIT_RXR) |
        (WORD_W'(1) << BIT_FFUL) | (WORD_W'(1) << BIT_TXR);
endpackage

// File: rtl/sport_irq_sync.sv
// Module: sport_irq_sync
// Multi-stage flip-flop synchroniser for a bus of independent asynchronous
// level signals. Assumes each bit is a slow level, so per-bit skew is harmless.
module sport_irq_sync #(
    parameter int STAGES = 2,
    parameter int W      = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    logic [W-1:0] stg_q [STAGES];

    // Shift the sampled inputs down the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
        end else begin
            stg_q[0] <= async_i;
            for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
        end
    end

    assign sync_o = stg_q[STAGES-1];
endmodule

// File: rtl/sport_irq_edge.sv
// Module: sport_irq_edge
// Rising-edge detector per line with a per-line enable. A rise is one cycle
// where the previous sample is 0 and the current one is 1. Assumes
// synchronised inputs.
module sport_irq_edge #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] en_i,
    output logic [W-1:0] rise_o
);
    logic [W-1:0] prev_q;

    // Remember the last sampled level of each line.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= cur_i;
    end

    for (genvar g = 0; g < W; g++) begin : g_line
        // Qualify the raw rise with its enable.
        assign rise_o[g] = cur_i[g] & ~prev_q[g] & en_i[g];

        // R11: after a rise, the line is remembered as high
        rise_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
            rise_o[g] |=> prev_q[g]);
        // R5: a disabled line never reports a rise
        rise_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !en_i[g] |-> !rise_o[g]);
    end
endmodule

// File: rtl/sport_irq_sticky.sv
// Module: sport_irq_sticky
// Sticky flag: set by a pulse, cleared by a strobe, set wins on a tie.
module sport_irq_sticky (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_q;

    // Hold the flag; a set in the same cycle as a clear keeps it high.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (set_i)  flag_q <= 1'b1;
        else if (clr_i)  flag_q <= 1'b0;
    end

    assign flag_o = flag_q;

    // R6: a set always leaves the flag high, even against a clear
    set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    // R7: the flag drops only after a clear
    clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flag_q) |-> $past(clr_i));
    // R5: the flag rises only after a set
    rise_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flag_q) |-> $past(set_i));
endmodule

// File: rtl/sport_irq_mask.sv
// Module: sport_irq_mask
// Software-writable mask register; resets to all-masked (zero).
module sport_irq_mask #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] mask_o
);
    logic [W-1:0] mask_q;

    // Load the mask on a write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)    mask_q <= '0;
        else if (we_i) mask_q <= wdata_i;
    end

    assign mask_o = mask_q;

    // R10: without a write the mask holds its value
    mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(mask_q));
endmodule

// File: rtl/sport_irq_top.sv
// Module: sport_irq_top
// Serial-port interrupt status and masking. Builds the read-only status word
// from the port-change flag, the overrun flag and four level sources, gates it
// with the mask and drives one interrupt. Assumes the event inputs are
// synchronous pulses or levels in the clk domain; only the modem inputs are
// treated as asynchronous.
module sport_irq_top
    import sport_irq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_we,
    input  logic [WORD_W-1:0] mask_wdata,
    input  logic              rd_sel,
    output logic [WORD_W-1:0] rd_data,
    input  logic              pchg_clr,
    input  logic              err_rst_cmd,
    input  logic              cd_in,
    input  logic              cts_in,
    input  logic              cd_edge_en,
    input  logic              cts_edge_en,
    input  logic              ovr_evt,
    input  logic              tx_empty,
    input  logic              rx_ready,
    input  logic              fifo_full,
    input  logic              tx_ready,
    output logic              irq
);
    logic [N_MODEM-1:0] modem_sync;
    logic [N_MODEM-1:0] modem_rise;
    logic               pchg_flag;
    logic               ovr_flag;
    logic [WORD_W-1:0]  mask_q;
    logic [WORD_W-1:0]  status;

    sport_irq_sync #(.STAGES(SYNC_STAGES), .W(N_MODEM)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({cts_in, cd_in}), .sync_o(modem_sync));

    sport_irq_edge #(.W(N_MODEM)) u_edge (
        .clk(clk), .rst_n(rst_n), .cur_i(modem_sync),
        .en_i({cts_edge_en, cd_edge_en}), .rise_o(modem_rise));

    sport_irq_sticky u_pchg (
        .clk(clk), .rst_n(rst_n), .set_i(|modem_rise),
        .clr_i(pchg_clr), .flag_o(pchg_flag));

    sport_irq_sticky u_ovr (
        .clk(clk), .rst_n(rst_n), .set_i(ovr_evt),
        .clr_i(err_rst_cmd), .flag_o(ovr_flag));

    sport_irq_mask #(.W(WORD_W)) u_mask (
        .clk(clk), .rst_n(rst_n), .we_i(mask_we),
        .wdata_i(mask_wdata), .mask_o(mask_q));

    // Assemble the status word; unlisted positions stay zero.
    always_comb begin
        status           = '0;
        status[BIT_PCHG] = pchg_flag;
        status[BIT_OVR]  = ovr_flag;
        status[BIT_TXE]  = tx_empty;
        status[BIT_RXR]  = rx_ready;
        status[BIT_FFUL] = fifo_full;
        status[BIT_TXR]  = tx_ready;
    end

    // Drive the interrupt from the masked status.
    assign irq     = |(status & mask_q);
    // Select the read-back register.
    assign rd_data = rd_sel ? mask_q : status;

    // R9
    rsvd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status & ~USED_MASK) == '0);
    // R2
    masked_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);
    // R2
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (status == '0) |-> !irq);
    // R7
    ovr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_flag && !err_rst_cmd) |=> ovr_flag);
endmodule

// File: tb/sim_sport_irq_top.sv
module sim_sport_irq_top;
    logic        clk = 1'b0;
    logic        rst_n, mask_we, rd_sel, pchg_clr, err_rst_cmd;
    logic [15:0] mask_wdata, rd_data;
    logic        cd_in, cts_in, cd_edge_en, cts_edge_en, ovr_evt;
    logic        tx_empty, rx_ready, fifo_full, tx_ready, irq;
    int          errs = 0;
    int          checks = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    sport_irq_top #(.SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .mask_we(mask_we), .mask_wdata(mask_wdata),
        .rd_sel(rd_sel), .rd_data(rd_data), .pchg_clr(pchg_clr),
        .err_rst_cmd(err_rst_cmd), .cd_in(cd_in), .cts_in(cts_in),
        .cd_edge_en(cd_edge_en), .cts_edge_en(cts_edge_en), .ovr_evt(ovr_evt),
        .tx_empty(tx_empty), .rx_ready(rx_ready), .fifo_full(fifo_full),
        .tx_ready(tx_ready), .irq(irq));

    // levels {tx_empty,rx_ready,fifo_full,tx_ready}, mask, expected status, expected irq
    localparam logic [36:0] VEC [8] = '{
        {4'b0000, 16'hFFFF, 16'h0000, 1'b0},
        {4'b1000, 16'h0000, 16'h0800, 1'b0},
        {4'b1000, 16'h0800, 16'h0800, 1'b1},
        {4'b0100, 16'h0800, 16'h0200, 1'b0},
        {4'b0110, 16'h0100, 16'h0300, 1'b1},
        {4'b0001, 16'h0080, 16'h0080, 1'b1},
        {4'b1111, 16'h7F7F, 16'h0B80, 1'b1},
        {4'b1111, 16'hF47F, 16'h0B80, 1'b0}
    };

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr_mask(input logic [15:0] m);
        mask_we = 1'b1; mask_wdata = m;
        step(1);
        mask_we = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errs++; checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst_n = 0; mask_we = 0; mask_wdata = 0; rd_sel = 0; pchg_clr = 0;
        err_rst_cmd = 0; cd_in = 0; cts_in = 0; cd_edge_en = 0; cts_edge_en = 0;
        ovr_evt = 0; tx_empty = 0; rx_ready = 0; fifo_full = 0; tx_ready = 0;
        step(3);
        chk("R1 status", rd_data, 16'h0000);
        chk("R1 irq", {15'd0, irq}, 16'h0000);
        rd_sel = 1; #1;
        chk("R1 mask", rd_data, 16'h0000);
        rd_sel = 0;
        rst_n = 1;
        step(1);

        // R10 mask read-back
        wr_mask(16'hA5C3);
        rd_sel = 1; #1;
        chk("R10 mask readback", rd_data, 16'hA5C3);
        rd_sel = 0;

        // R2 R8 R9 vector table
        foreach (VEC[i]) begin
            {tx_empty, rx_ready, fifo_full, tx_ready} = VEC[i][36:33];
            wr_mask(VEC[i][32:17]);
            chk("R8/R9 status", rd_data, VEC[i][16:1]);
            chk("R2 irq", {15'd0, irq}, {15'd0, VEC[i][0]});
        end
        {tx_empty, rx_ready, fifo_full, tx_ready} = 4'b0000;

        // R3 carrier-detect edge, three-edge latency
        wr_mask(16'h8000);
        cd_edge_en = 1; cd_in = 1;
        step(2);
        chk("R3 not yet", rd_data, 16'h0000);
        step(1);
        chk("R3 pchg set", rd_data, 16'h8000);
        chk("R2 pchg irq", {15'd0, irq}, 16'h0001);
        // R6 clear
        pchg_clr = 1; step(1); pchg_clr = 0;
        chk("R6 cleared", rd_data, 16'h0000);
        // R11 steady high, then falling
        step(4);
        chk("R11 steady high", rd_data, 16'h0000);
        cd_in = 0; step(4);
        chk("R11 falling", rd_data, 16'h0000);
        // R5 disabled carrier detect
        cd_edge_en = 0; cd_in = 1; step(4);
        chk("R5 cd disabled", rd_data, 16'h0000);
        cd_in = 0; step(3);

        // R4 clear-to-send edge
        cts_edge_en = 1; cts_in = 1; step(3);
        chk("R4 pchg set", rd_data, 16'h8000);
        pchg_clr = 1; step(1); pchg_clr = 0;
        // R6 edge and clear in same cycle
        cts_in = 0; step(3);
        cts_in = 1; step(2);
        pchg_clr = 1; step(1); pchg_clr = 0;
        chk("R6 set wins", rd_data, 16'h8000);
        pchg_clr = 1; step(1); pchg_clr = 0;
        // R5 disabled clear-to-send
        cts_edge_en = 0; cts_in = 0; step(3);
        cts_in = 1; step(4);
        chk("R5 cts disabled", rd_data, 16'h0000);

        // R7 overrun
        wr_mask(16'h1000);
        ovr_evt = 1; step(1); ovr_evt = 0;
        chk("R7 ovr set", rd_data, 16'h1000);
        chk("R7 ovr irq", {15'd0, irq}, 16'h0001);
        pchg_clr = 1; step(1); pchg_clr = 0;
        chk("R7 survives pchg clr", rd_data, 16'h1000);
        wr_mask(16'hFFFF);
        chk("R7 survives mask write", rd_data, 16'h1000);
        err_rst_cmd = 1; step(1); err_rst_cmd = 0;
        chk("R7 cmd clears", rd_data, 16'h0000);
        ovr_evt = 1; err_rst_cmd = 1; step(1); ovr_evt = 0; err_rst_cmd = 0;
        chk("R7 set wins", rd_data, 16'h1000);

        // R1 reset mid-run
        rst_n = 0; step(1);
        chk("R1 status rerun", rd_data, 16'h0000);
        chk("R1 irq rerun", {15'd0, irq}, 16'h0000);
        rd_sel = 1; #1;
        chk("R1 mask rerun", rd_data, 16'h0000);
        rd_sel = 0;

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule